// File: doc/BRIEF.md
# Always-On Shadow Write-Index Bank

This block holds ring write indices for a group of copy engines whose register file sits in a power-gated domain. It lives in an always-powered domain. The host posts write-index updates to one of 24 shadow slots at any time, whatever the engine domain's power state. A fixed sparse table turns each usable slot into an engine number and a ring direction: source or destination. When the engine domain is up and idle, an update reaches the engine register port in the next cycle. When the domain is down, the bank keeps the newest value for each slot and marks the slot as owed. Once power returns, it replays every owed slot to the engine port.

The host port is a write-only valid/ready stream. Its ready output is always high, so the host is never back-pressured and never has to know the power state. The engine port is a valid/ready stream.
- While power-good stays high, a presented write keeps its engine, direction and data unchanged until ready is seen high.
- A presented write is withdrawn only when the power-good input falls. It is then queued again and sent after power returns.

A write to a slot with no mapping changes no state. It raises a sticky error flag that only reset clears.

Top module: `aon_shadow_bank`

## Requirements
- R1: Host writes to slots 0, 3, 4, 5 and 7 reach the engine port with the engine number equal to the slot number and the direction bit 0 (source ring).
- R2: Host writes to slots 13, 14, 19, 20, 21, 22 and 23 reach the engine port with engines 1, 2, 7, 8, 9, 10 and 11 respectively and the direction bit 1 (destination ring).
- R3: A host write to an unmapped slot (1, 2, 6, 8 to 12, 15 to 18, 24 to 31) produces no engine write and sets the error flag in the next cycle. The flag stays set until reset.
- R4: The host port's ready output is high in every cycle after reset, in either power state.
- R5: While power-good is low, no engine write is presented. Host writes to mapped slots are kept for later replay.
- R6: When a slot is written more than once before it is replayed, only the last value is sent, in exactly one engine write.
- R7: When power-good has been high for two rising clock edges, owed slots are sent in ascending slot order. The first write is visible after the second edge, and one write is sent per cycle while engine ready is high.
- R8: With power up, nothing owed and the engine port idle, a mapped host write shows on the engine port in the cycle after it is accepted. It is sent once only.
- R9: A host write during replay to a slot that has already been sent is sent again, with the new value, before the engine port goes idle.
- R10: While engine valid is high, engine ready is low and power-good stays high, the engine port's engine, direction and data do not change. This holds even if a lower slot is written meanwhile.
- R11: If power-good falls while a write is presented and not yet accepted, engine valid drops. That write is sent after power returns.
- R12: After reset, engine valid and the error flag are low and no slot is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Engine domain is powered |
| hw_valid | input | 1 | Host write request |
| hw_ready | output | 1 | Host write accepted (always high after reset) |
| hw_slot | input | 5 | Shadow slot number |
| hw_data | input | IDX_W | Write-index value |
| eg_valid | output | 1 | Engine register write presented |
| eg_ready | input | 1 | Engine register file accepts the write |
| eg_engine | output | 4 | Target engine number |
| eg_dst | output | 1 | 0 = source ring index, 1 = destination ring index |
| eg_data | output | IDX_W | Write-index value for the engine |
| map_err | output | 1 | Sticky flag: an unmapped slot was written |

## Verification
Several properties are checked every cycle by the assertions:
- the engine port holds still under back-pressure while power stays up;
- it is silent one cycle after power is seen low;
- an idle-time write comes out on the next cycle with its data intact;
- the error flag sets on a bad slot and never clears.

The slot-to-engine table, the ascending replay order, the collapsing of repeated writes to one, the second pass for a slot rewritten during replay, and the requeue after a power drop all depend on sequences of several writes. Only the bench's scenarios show these.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int NUM_SLOTS = 24;
  localparam int SLOT_W    = 5;
  localparam int ENG_W     = 4;

  typedef struct packed {
    logic             ok;
    logic             dst;
    logic [ENG_W-1:0] eng;
  } smap_t;

  // Fixed sparse table: shadow slot -> engine and ring direction.
  function automatic smap_t slot_lookup(input logic [SLOT_W-1:0] s);
    smap_t m;
    m = '0;
    case (s)
      5'd0:  m = '{ok: 1'b1, dst: 1'b0, eng: 4'd0};
      5'd3:  m = '{ok: 1'b1, dst: 1'b0, eng: 4'd3};
      5'd4:  m = '{ok: 1'b1, dst: 1'b0, eng: 4'd4};
      5'd5:  m = '{ok: 1'b1, dst: 1'b0, eng: 4'd5};
      5'd7:  m = '{ok: 1'b1, dst: 1'b0, eng: 4'd7};
      5'd13: m = '{ok: 1'b1, dst: 1'b1, eng: 4'd1};
      5'd14: m = '{ok: 1'b1, dst: 1'b1, eng: 4'd2};
      5'd19: m = '{ok: 1'b1, dst: 1'b1, eng: 4'd7};
      5'd20: m = '{ok: 1'b1, dst: 1'b1, eng: 4'd8};
      5'd21: m = '{ok: 1'b1, dst: 1'b1, eng: 4'd9};
      5'd22: m = '{ok: 1'b1, dst: 1'b1, eng: 4'd10};
      5'd23: m = '{ok: 1'b1, dst: 1'b1, eng: 4'd11};
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/shadow_decode.sv
module shadow_decode
  import shadow_pkg::*;
(
  input  logic                 hw_valid,
  input  logic [SLOT_W-1:0]    hw_slot,
  output logic [NUM_SLOTS-1:0] hit,
  output logic                 bad
);
  smap_t cur;

  always_comb begin
    cur = slot_lookup(hw_slot);
    bad = hw_valid && !cur.ok;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
    localparam smap_t M = slot_lookup(SLOT_W'(i));
    if (M.ok) begin : g_map
      assign hit[i] = hw_valid && (hw_slot == SLOT_W'(i));
    end else begin : g_nomap
      assign hit[i] = 1'b0;
    end
  end
endmodule

// File: rtl/shadow_store.sv
module shadow_store
  import shadow_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SLOTS-1:0]             hit,
  input  logic [IDX_W-1:0]                 hw_data,
  input  logic [NUM_SLOTS-1:0]             clr,
  input  logic [NUM_SLOTS-1:0]             req,
  output logic [NUM_SLOTS-1:0]             pend,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0]  vals
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam smap_t M = slot_lookup(SLOT_W'(i));
    if (M.ok) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend[i] <= 1'b0;
          vals[i] <= '0;
        end else begin
          if (hit[i]) vals[i] <= hw_data;
          // issue wins: the sequencer consumed the newest value this cycle
          if (clr[i])                pend[i] <= 1'b0;
          else if (hit[i] || req[i]) pend[i] <= 1'b1;
        end
      end
    end else begin : g_dead
      assign pend[i] = 1'b0;
      assign vals[i] = '0;
    end
  end
endmodule

// File: rtl/shadow_replay.sv
module shadow_replay
  import shadow_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             pwr_good,
  input  logic [NUM_SLOTS-1:0]             hit,
  input  logic [IDX_W-1:0]                 hw_data,
  input  logic [NUM_SLOTS-1:0]             pend,
  input  logic [NUM_SLOTS-1:0][IDX_W-1:0]  vals,
  output logic [NUM_SLOTS-1:0]             clr,
  output logic [NUM_SLOTS-1:0]             req,
  input  logic                             eg_ready,
  output logic                             eg_valid,
  output logic [ENG_W-1:0]                 eg_engine,
  output logic                             eg_dst,
  output logic [IDX_W-1:0]                 eg_data
);
  logic                 pg_q;
  logic                 out_v;
  logic [SLOT_W-1:0]    out_slot;
  logic [IDX_W-1:0]     out_data;
  logic [NUM_SLOTS-1:0] eff;
  logic [SLOT_W-1:0]    pick;
  logic                 any;
  logic                 load;
  smap_t                om;

  // Owed slots plus the write arriving now (bypass for the idle case).
  assign eff = pend | hit;
  assign any = |eff;

  always_comb begin
    pick = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (eff[i]) pick = SLOT_W'(i);
    end
  end

  assign load = pg_q && any && (!out_v || eg_ready);

  always_comb begin
    clr = '0;
    req = '0;
    if (load) clr[pick] = 1'b1;
    if (!pg_q && out_v && !eg_ready) req[out_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q     <= 1'b0;
      out_v    <= 1'b0;
      out_slot <= '0;
      out_data <= '0;
    end else begin
      pg_q <= pwr_good;
      if (!pg_q) begin
        out_v <= 1'b0;
      end else if (load) begin
        out_v    <= 1'b1;
        out_slot <= pick;
        out_data <= hit[pick] ? hw_data : vals[pick];
      end else if (out_v && eg_ready) begin
        out_v <= 1'b0;
      end
    end
  end

  assign om        = slot_lookup(out_slot);
  assign eg_valid  = out_v;
  assign eg_engine = om.eng;
  assign eg_dst    = om.dst;
  assign eg_data   = out_data;

  // R10: presented write holds under back-pressure while power stays up
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eg_valid && !eg_ready && pg_q && pwr_good) |=>
      (eg_valid && $stable(eg_engine) && $stable(eg_dst) && $stable(eg_data)));

  // R5: nothing presented once the domain is seen unpowered
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_q |=> !eg_valid);

  // R8: idle, powered, nothing owed: the write appears next cycle unchanged
  a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit) && pg_q && (pend == '0) && !eg_valid) |=>
      (eg_valid && eg_data == $past(hw_data)));
endmodule

// File: rtl/aon_shadow_bank.sv
module aon_shadow_bank
  import shadow_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_good,
  input  logic                 hw_valid,
  output logic                 hw_ready,
  input  logic [SLOT_W-1:0]    hw_slot,
  input  logic [IDX_W-1:0]     hw_data,
  output logic                 eg_valid,
  input  logic                 eg_ready,
  output logic [ENG_W-1:0]     eg_engine,
  output logic                 eg_dst,
  output logic [IDX_W-1:0]     eg_data,
  output logic                 map_err
);
  logic [NUM_SLOTS-1:0]            hit, clr, req, pend;
  logic [NUM_SLOTS-1:0][IDX_W-1:0] vals;
  logic                            bad;
  logic                            err_q;

  shadow_decode u_dec (
    .hw_valid (hw_valid),
    .hw_slot  (hw_slot),
    .hit      (hit),
    .bad      (bad)
  );

  shadow_store #(.IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .hw_data (hw_data),
    .clr     (clr),
    .req     (req),
    .pend    (pend),
    .vals    (vals)
  );

  shadow_replay #(.IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .hit       (hit),
    .hw_data   (hw_data),
    .pend      (pend),
    .vals      (vals),
    .clr       (clr),
    .req       (req),
    .eg_ready  (eg_ready),
    .eg_valid  (eg_valid),
    .eg_engine (eg_engine),
    .eg_dst    (eg_dst),
    .eg_data   (eg_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end

  assign map_err  = err_q;
  assign hw_ready = rst_n;

  // R3: flag never clears on its own
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |=> map_err);

  // R3: an unmapped slot write raises the flag next cycle
  a_r3_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && !slot_lookup(hw_slot).ok) |=> map_err);
endmodule

// File: tb/sim_aon_shadow_bank.sv
module sim_aon_shadow_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_good = 1'b0;
  logic        hw_valid = 1'b0;
  logic        hw_ready;
  logic [4:0]  hw_slot = '0;
  logic [15:0] hw_data = '0;
  logic        eg_valid;
  logic        eg_ready = 1'b1;
  logic [3:0]  eg_engine;
  logic        eg_dst;
  logic [15:0] eg_data;
  logic        map_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  aon_shadow_bank #(.IDX_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_slot(hw_slot), .hw_data(hw_data),
    .eg_valid(eg_valid), .eg_ready(eg_ready), .eg_engine(eg_engine),
    .eg_dst(eg_dst), .eg_data(eg_data), .map_err(map_err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // {slot, data, mapped, engine, dst}
  localparam int NV = 14;
  localparam logic [26:0] VEC [NV] = '{
    {5'd0,  16'h1000, 1'b1, 4'd0,  1'b0},
    {5'd3,  16'h1003, 1'b1, 4'd3,  1'b0},
    {5'd4,  16'h1004, 1'b1, 4'd4,  1'b0},
    {5'd5,  16'h1005, 1'b1, 4'd5,  1'b0},
    {5'd7,  16'h1007, 1'b1, 4'd7,  1'b0},
    {5'd13, 16'h2013, 1'b1, 4'd1,  1'b1},
    {5'd14, 16'h2014, 1'b1, 4'd2,  1'b1},
    {5'd19, 16'h2019, 1'b1, 4'd7,  1'b1},
    {5'd20, 16'h2020, 1'b1, 4'd8,  1'b1},
    {5'd21, 16'h2021, 1'b1, 4'd9,  1'b1},
    {5'd22, 16'h2022, 1'b1, 4'd10, 1'b1},
    {5'd23, 16'h2023, 1'b1, 4'd11, 1'b1},
    {5'd6,  16'h3006, 1'b0, 4'd0,  1'b0},
    {5'd27, 16'h3027, 1'b0, 4'd0,  1'b0}
  };

  task automatic hwrite(input logic [4:0] s, input logic [15:0] d);
    hw_valid = 1'b1; hw_slot = s; hw_data = d;
    @(negedge clk);
    hw_valid = 1'b0;
  endtask

  // collect accepted engine writes into a queue, up to a cycle limit
  logic [20:0] got [$];
  task automatic grab(input int cyc);
    for (int c = 0; c < cyc; c++) begin
      if (eg_valid && eg_ready) got.push_back({eg_engine, eg_dst, eg_data});
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(eg_valid == 1'b0, "R12 valid", eg_valid, 0);
    chk(map_err == 1'b0, "R12 err", map_err, 0);
    chk(hw_ready == 1'b1, "R4 ready up", hw_ready, 1);

    // table walk: powered, idle forwarding (R1, R2, R3, R8)
    pwr_good = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      logic [4:0] s; logic [15:0] d; logic m; logic [3:0] e; logic ds;
      {s, d, m, e, ds} = VEC[v];
      hwrite(s, d);
      chk(eg_valid == m, "R8 forward valid", eg_valid, m);
      if (m) begin
        chk(eg_engine == e && eg_dst == ds && eg_data == d,
            ds ? "R2 dst map" : "R1 src map",
            {eg_engine, eg_dst, eg_data}, {e, ds, d});
      end else begin
        chk(map_err == 1'b1, "R3 err set", map_err, 1);
      end
      @(negedge clk);
      chk(eg_valid == 1'b0, "R8 single write", eg_valid, 0);
    end
    hwrite(5'd0, 16'h0abc);
    @(negedge clk);
    chk(map_err == 1'b1, "R3 err sticky", map_err, 1);

    // power down: hold and replay in order, latest value only (R5, R6, R7)
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    chk(hw_ready == 1'b1, "R4 ready while down", hw_ready, 1);
    hwrite(5'd20, 16'h0020);
    hwrite(5'd3,  16'h0a03);
    hwrite(5'd13, 16'h0013);
    hwrite(5'd3,  16'h0b03);
    repeat (4) @(negedge clk);
    chk(eg_valid == 1'b0, "R5 quiet while down", eg_valid, 0);
    pwr_good = 1'b1;
    @(negedge clk);
    chk(eg_valid == 1'b0, "R7 not before second edge", eg_valid, 0);
    @(negedge clk);
    chk(eg_valid == 1'b1, "R7 starts after second edge", eg_valid, 1);
    got.delete();
    grab(10);
    chk(got.size() == 3, "R6 count", got.size(), 3);
    if (got.size() == 3) begin
      chk(got[0] == {4'd3, 1'b0, 16'h0b03}, "R6 latest first", got[0], {4'd3, 1'b0, 16'h0b03});
      chk(got[1] == {4'd1, 1'b1, 16'h0013}, "R7 order 2", got[1], {4'd1, 1'b1, 16'h0013});
      chk(got[2] == {4'd8, 1'b1, 16'h0020}, "R7 order 3", got[2], {4'd8, 1'b1, 16'h0020});
    end

    // rewrite of an already replayed slot during replay (R9)
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    hwrite(5'd0,  16'h0100);
    hwrite(5'd4,  16'h0104);
    hwrite(5'd5,  16'h0105);
    hwrite(5'd7,  16'h0107);
    hwrite(5'd23, 16'h0123);
    pwr_good = 1'b1;
    got.delete();
    begin
      bit redone = 0;
      for (int c = 0; c < 20; c++) begin
        if (eg_valid && eg_ready) begin
          got.push_back({eg_engine, eg_dst, eg_data});
          if (!redone && eg_engine == 4'd4 && !eg_dst) begin
            redone = 1;
            hw_valid = 1'b1; hw_slot = 5'd0; hw_data = 16'h0200;
          end
        end
        @(negedge clk);
        hw_valid = 1'b0;
      end
    end
    chk(got.size() == 6, "R9 count", got.size(), 6);
    if (got.size() == 6) begin
      chk(got[2] == {4'd0, 1'b0, 16'h0200}, "R9 rewrite sent", got[2], {4'd0, 1'b0, 16'h0200});
      chk(got[5] == {4'd11, 1'b1, 16'h0123}, "R9 tail", got[5], {4'd11, 1'b1, 16'h0123});
    end

    // back-pressure hold with a lower slot written meanwhile (R10)
    eg_ready = 1'b0;
    hwrite(5'd14, 16'h0e14);
    chk(eg_valid && eg_engine == 4'd2 && eg_data == 16'h0e14, "R10 presented",
        {eg_engine, eg_data}, {4'd2, 16'h0e14});
    hwrite(5'd0, 16'h0e00);
    repeat (3) @(negedge clk);
    chk(eg_valid && eg_engine == 4'd2 && eg_dst && eg_data == 16'h0e14, "R10 held",
        {eg_engine, eg_data}, {4'd2, 16'h0e14});
    eg_ready = 1'b1;
    got.delete();
    grab(5);
    chk(got.size() == 2 && got[0] == {4'd2, 1'b1, 16'h0e14} && got[1] == {4'd0, 1'b0, 16'h0e00},
        "R10 release order", got.size(), 2);

    // power loss with a write presented (R11)
    eg_ready = 1'b0;
    hwrite(5'd21, 16'h0f21);
    chk(eg_valid == 1'b1, "R11 presented", eg_valid, 1);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    chk(eg_valid == 1'b0, "R11 withdrawn", eg_valid, 0);
    eg_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(eg_valid == 1'b0, "R5 still quiet", eg_valid, 0);
    pwr_good = 1'b1;
    got.delete();
    grab(6);
    chk(got.size() == 1 && got[0] == {4'd9, 1'b1, 16'h0f21}, "R11 resent",
        got.size(), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule